// File: doc/BRIEF.md
# Status Pin Mode Controller

This block drives the ready/busy status pin of a flash-style write state machine. The pin is open-drain: it is either pulled low or released to high impedance. It is modelled here as a single enable, `sts_oe`. When `sts_oe` is 1 the pin is pulled low. When it is 0 the pin floats.

Two kinds of behaviour are available. In the default level mode the pin tracks the state machine's busy flag. In each of three pulse modes the pin gives a short low pulse when an operation completes, and can serve as an interrupt. Each pulse mode reacts to its own group of operation types.

A configuration command carries a code that selects the mode. The mode stays in force until one of three things happens: another valid command arrives, the power-down indication is raised, or the device reset input is pulled low. Power-down and device reset both return the block to level mode.

Top module: `sts_ctrl`

## Requirements
- R1: After `rst`, the block is in level mode and `sts_oe` is 0.
- R2: In level mode (code 0), `sts_oe` at each clock edge takes the value of `busy` sampled at that edge. The five completion strobes have no effect in this mode.
- R3: Code 1 selects erase pulse mode. A pulse follows `done_blk_erase`, `done_chip_erase` or `done_lock_clr`. It does not follow `done_byte_wr` or `done_lock_set`.
- R4: Code 2 selects write pulse mode. A pulse follows `done_byte_wr` or `done_lock_set`. It does not follow any of the three erase-type strobes.
- R5: Code 3 selects a pulse for each of the five completion strobes.
- R6: In a pulse mode, a selected strobe sampled at edge k makes `sts_oe` 1 from edge k+1 for exactly `PULSE_LEN` cycles. Outside a pulse, `sts_oe` is 0 and `busy` is ignored.
- R7: A selected strobe that arrives while a pulse is active restarts the count. `sts_oe` then stays 1 for `PULSE_LEN` cycles after the edge after that strobe.
- R8: A command with a code above 3 is ignored and the current mode is kept. A valid command sampled at edge k governs the inputs sampled from edge k+1 on.
- R9: If `pwr_dn` is 1 or `dev_rst_n` is 0 at an edge, the block returns to level mode and cancels any pulse in progress. A command issued while `dev_rst_n` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| dev_rst_n | input | 1 | Device reset, active low; forces level mode and blocks commands |
| pwr_dn | input | 1 | Power-down indication; forces level mode |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_code | input | CODE_W | Configuration code; 0 to 3 are valid |
| busy | input | 1 | Write state machine busy flag |
| done_blk_erase | input | 1 | One-cycle completion strobe, block erase |
| done_chip_erase | input | 1 | One-cycle completion strobe, full chip erase |
| done_lock_clr | input | 1 | One-cycle completion strobe, clear lock bits |
| done_byte_wr | input | 1 | One-cycle completion strobe, byte or multi-byte write |
| done_lock_set | input | 1 | One-cycle completion strobe, set lock bit |
| sts_oe | output | 1 | Status pin pull-low enable; 0 means high impedance |

## Verification
The mode register cannot be read directly. The bench therefore judges the mode only from the pin. A wrong mode appears within two edges: either `sts_oe` follows `busy` when it should not, or it ignores `busy` when it should follow it. It also shows when a strobe produces a pulse, or fails to produce one, against what the selected operation group predicts. A fault in the pulse counter shows as a pulse one or more cycles too long or too short, or as a restart that does not extend the pulse. A missed reset or power-down shows when the next busy cycle is not reflected on the pin.

// File: rtl/sts_pkg.sv
package sts_pkg;

  typedef enum logic [1:0] {
    MODE_LEVEL = 2'd0,
    MODE_ERASE = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_ALL   = 2'd3
  } sts_mode_e;

  localparam int OP_COUNT      = 5;
  localparam int OP_BLK_ERASE  = 0;
  localparam int OP_CHIP_ERASE = 1;
  localparam int OP_LOCK_CLR   = 2;
  localparam int OP_BYTE_WR    = 3;
  localparam int OP_LOCK_SET   = 4;

  localparam logic [OP_COUNT-1:0] ERASE_SET =
    (OP_COUNT'(1) << OP_BLK_ERASE) | (OP_COUNT'(1) << OP_CHIP_ERASE) |
    (OP_COUNT'(1) << OP_LOCK_CLR);
  localparam logic [OP_COUNT-1:0] WRITE_SET =
    (OP_COUNT'(1) << OP_BYTE_WR) | (OP_COUNT'(1) << OP_LOCK_SET);

  function automatic logic [OP_COUNT-1:0] op_mask(sts_mode_e m);
    case (m)
      MODE_ERASE: return ERASE_SET;
      MODE_WRITE: return WRITE_SET;
      MODE_ALL:   return ERASE_SET | WRITE_SET;
      default:    return '0;
    endcase
  endfunction

endpackage

// File: rtl/sts_mode_reg.sv
module sts_mode_reg
  import sts_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_dflt,
  input  logic              cfg_valid,
  input  logic [CODE_W-1:0] cfg_code,
  output sts_mode_e         mode_q
);
  logic code_ok;

  // Only codes 0..3 are legal; every upper bit must be zero.
  assign code_ok = (cfg_code[CODE_W-1:2] == '0);

  always_ff @(posedge clk) begin
    if (rst || force_dflt) begin
      mode_q <= MODE_LEVEL;
    end else if (cfg_valid && code_ok) begin
      mode_q <= sts_mode_e'(cfg_code[1:0]);
    end
  end
endmodule

// File: rtl/sts_event_sel.sv
module sts_event_sel
  import sts_pkg::*;
(
  input  sts_mode_e            mode,
  input  logic [OP_COUNT-1:0]  done_vec,
  output logic                 hit
);
  logic [OP_COUNT-1:0] mask;
  logic [OP_COUNT-1:0] sel;

  assign mask = op_mask(mode);

  for (genvar i = 0; i < OP_COUNT; i++) begin : g_op
    assign sel[i] = done_vec[i] & mask[i];
  end

  assign hit = |sel;
endmodule

// File: rtl/sts_pulse_timer.sv
module sts_pulse_timer #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic trig,
  output logic active
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (trig) begin
      active <= 1'b1;
      cnt    <= LOAD;
    end else if (active) begin
      if (cnt == '0) begin
        active <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sts_out_stage.sv
module sts_out_stage
  import sts_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  sts_mode_e mode,
  input  logic      busy,
  input  logic      pulse_act,
  output logic      oe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= 1'b0;
    end else if (mode == MODE_LEVEL) begin
      oe_q <= busy;
    end else begin
      oe_q <= pulse_act;
    end
  end
endmodule

// File: rtl/sts_ctrl.sv
module sts_ctrl
  import sts_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_rst_n,
  input  logic              pwr_dn,
  input  logic              cfg_valid,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              busy,
  input  logic              done_blk_erase,
  input  logic              done_chip_erase,
  input  logic              done_lock_clr,
  input  logic              done_byte_wr,
  input  logic              done_lock_set,
  output logic              sts_oe
);
  sts_mode_e           mode_q;
  logic                force_dflt;
  logic [OP_COUNT-1:0] done_vec;
  logic                done_hit;
  logic                pulse_act;
  logic                timer_clr;

  assign force_dflt = !dev_rst_n || pwr_dn;
  assign timer_clr  = force_dflt || (mode_q == MODE_LEVEL);

  always_comb begin
    done_vec                = '0;
    done_vec[OP_BLK_ERASE]  = done_blk_erase;
    done_vec[OP_CHIP_ERASE] = done_chip_erase;
    done_vec[OP_LOCK_CLR]   = done_lock_clr;
    done_vec[OP_BYTE_WR]    = done_byte_wr;
    done_vec[OP_LOCK_SET]   = done_lock_set;
  end

  sts_mode_reg #(.CODE_W(CODE_W)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .force_dflt(force_dflt),
    .cfg_valid (cfg_valid),
    .cfg_code  (cfg_code),
    .mode_q    (mode_q)
  );

  sts_event_sel u_sel (
    .mode    (mode_q),
    .done_vec(done_vec),
    .hit     (done_hit)
  );

  sts_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (timer_clr),
    .trig  (done_hit),
    .active(pulse_act)
  );

  sts_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_q),
    .busy     (busy),
    .pulse_act(pulse_act),
    .oe_q     (sts_oe)
  );
endmodule

// File: rtl/sts_ctrl_chk.sv
module sts_ctrl_chk
  import sts_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dev_rst_n,
  input logic              pwr_dn,
  input logic              cfg_valid,
  input logic [CODE_W-1:0] cfg_code,
  input logic              busy,
  input logic              sts_oe,
  input sts_mode_e         mode_q,
  input logic              done_hit,
  input logic              pulse_act
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1: reset leaves the pin released
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !sts_oe);

  // R2: level mode tracks busy one edge later
  p_level_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(mode_q) == MODE_LEVEL) |-> (sts_oe == $past(busy)));

  // R2: no pulse survives in level mode
  p_level_no_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LEVEL) |=> !pulse_act);

  // R6: a pulse starts only after a selected strobe
  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && pulse_act && !$past(pulse_act)) |-> $past(done_hit));

  // R8: out-of-range code keeps the mode
  p_bad_code_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && (cfg_code > CODE_W'(3)) && dev_rst_n && !pwr_dn) |=> $stable(mode_q));

  // R9: power-down or device reset forces default
  p_force_dflt_r9: assert property (@(posedge clk) disable iff (rst)
    (!dev_rst_n || pwr_dn) |=> (mode_q == MODE_LEVEL && !pulse_act));
endmodule

bind sts_ctrl sts_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dev_rst_n(dev_rst_n),
  .pwr_dn   (pwr_dn),
  .cfg_valid(cfg_valid),
  .cfg_code (cfg_code),
  .busy     (busy),
  .sts_oe   (sts_oe),
  .mode_q   (mode_q),
  .done_hit (done_hit),
  .pulse_act(pulse_act)
);

// File: tb/test_sts_ctrl.sv
module test_sts_ctrl;
  localparam int CODE_W    = 8;
  localparam int PULSE_LEN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dev_rst_n = 1'b1;
  logic pwr_dn = 1'b0;
  logic cfg_valid = 1'b0;
  logic [CODE_W-1:0] cfg_code = '0;
  logic busy = 1'b0;
  logic [4:0] done = '0;   // 0 blk erase, 1 chip erase, 2 lock clr, 3 byte wr, 4 lock set
  logic sts_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sts_ctrl #(.CODE_W(CODE_W), .PULSE_LEN(PULSE_LEN)) i_sts_ctrl (
    .clk(clk), .rst(rst), .dev_rst_n(dev_rst_n), .pwr_dn(pwr_dn),
    .cfg_valid(cfg_valid), .cfg_code(cfg_code), .busy(busy),
    .done_blk_erase(done[0]), .done_chip_erase(done[1]), .done_lock_clr(done[2]),
    .done_byte_wr(done[3]), .done_lock_set(done[4]), .sts_oe(sts_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic configure(input logic [CODE_W-1:0] code);
    cfg_valid = 1'b1; cfg_code = code;
    tick(1);
    cfg_valid = 1'b0; cfg_code = '0;
  endtask

  // fires one strobe and returns how many cycles sts_oe stays high
  task automatic pulse_width(input int op, output int hits);
    hits = 0;
    done[op] = 1'b1;
    tick(1);
    done = '0;
    for (int i = 0; i < PULSE_LEN + 3; i++) begin
      tick(1);
      if (sts_oe) hits++;
    end
  endtask

  task automatic busy_echo(output int seen);
    busy = 1'b1;
    tick(1);
    seen = sts_oe;
    busy = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    check("R1 oe after reset", sts_oe, 0);
  endtask

  task automatic t_level();
    int seen;
    int hits;
    busy_echo(seen);
    check("R2 busy drives pin", seen, 1);
    check("R2 idle releases pin", sts_oe, 0);
    pulse_width(0, hits);
    check("R2 strobe ignored in level mode", hits, 0);
  endtask

  task automatic t_mode(input int code, input logic [4:0] sel, input string req);
    int hits;
    configure(CODE_W'(code));
    for (int op = 0; op < 5; op++) begin
      pulse_width(op, hits);
      check($sformatf("%s op %0d", req, op), hits, sel[op] ? PULSE_LEN : 0);
    end
  endtask

  task automatic t_pulse_timing();
    int seen;
    configure(8'd3);
    done[3] = 1'b1;
    tick(1);
    done = '0;
    check("R6 no pulse on strobe edge", sts_oe, 0);
    tick(1);
    check("R6 pulse starts next edge", sts_oe, 1);
    tick(PULSE_LEN - 1);
    check("R6 pulse last cycle", sts_oe, 1);
    tick(1);
    check("R6 pulse ended", sts_oe, 0);
    busy_echo(seen);
    check("R6 busy ignored in pulse mode", seen, 0);
  endtask

  task automatic t_restart();
    int hits = 0;
    configure(8'd3);
    done[0] = 1'b1; tick(1); done = '0;
    tick(1); if (sts_oe) hits++;
    tick(1); if (sts_oe) hits++;
    done[1] = 1'b1; tick(1); done = '0;
    if (sts_oe) hits++;
    for (int i = 0; i < PULSE_LEN + 3; i++) begin
      tick(1);
      if (sts_oe) hits++;
    end
    check("R7 restart extends pulse", hits, 3 + PULSE_LEN);
  endtask

  task automatic t_bad_code();
    int hits;
    configure(8'd2);
    configure(8'd5);
    pulse_width(3, hits);
    check("R8 code 5 ignored keeps write mode", hits, PULSE_LEN);
    configure(8'hFF);
    pulse_width(0, hits);
    check("R8 code FF ignored keeps write mode", hits, 0);
  endtask

  task automatic t_force_default();
    int seen;
    int hits;
    configure(8'd3);
    pwr_dn = 1'b1; tick(1); pwr_dn = 1'b0;
    busy_echo(seen);
    check("R9 power-down restores level mode", seen, 1);
    configure(8'd1);
    dev_rst_n = 1'b0; tick(1); dev_rst_n = 1'b1;
    busy_echo(seen);
    check("R9 device reset restores level mode", seen, 1);
    dev_rst_n = 1'b0; cfg_valid = 1'b1; cfg_code = 8'd3;
    tick(1);
    dev_rst_n = 1'b1; cfg_valid = 1'b0; cfg_code = '0;
    pulse_width(4, hits);
    check("R9 command ignored during device reset", hits, 0);
    configure(8'd3);
    done[2] = 1'b1; tick(1); done = '0;
    pwr_dn = 1'b1; tick(1); pwr_dn = 1'b0;
    tick(1);
    check("R9 power-down cancels pulse", sts_oe, 0);
    tick(PULSE_LEN);
    check("R9 pulse stays cancelled", sts_oe, 0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_level();
    t_mode(1, 5'b00111, "R3 erase mode");
    t_mode(2, 5'b11000, "R4 write mode");
    t_mode(3, 5'b11111, "R5 all mode");
    t_pulse_timing();
    t_restart();
    t_bad_code();
    t_force_default();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule